// File: doc/BRIEF.md
# Vectored Priority Interrupt Arbiter

The arbiter takes two classes of interrupt requests, a normal class and a fast class. Each class has up to 32 already-masked request lines. For each class it produces one registered request line and a 32-bit vector word that the processor can use directly as the address of the matching service routine. Every source carries a 3-bit priority field. The two classes use the same set of fields. Within a class, the block presents the most urgent active source. The vector word is formed by placing a programmable 16-bit base above the winning source number.

Nested service is tracked per class with a small stack of priority levels. When the processor acknowledges a presented request, the level of that request is pushed onto the stack. An end-of-service strobe pops it. While service is in progress, a new request is presented only if it is strictly more urgent than the level on top of the stack. The fast class outranks the normal class: the normal request line is held low while a fast request is presented or fast service is under way. Each class can also be switched out of vectored mode. In that mode it simply forwards the OR of its requests.

Top module: `vic_arbiter`

## Requirements
- R1: The priority code of source i is `prio_i[3i+2:3i]`. Code 0 means level 1, the most urgent, and code 7 means level 8. The candidate of a class is the active source with the smallest code. When codes are equal, the lowest source index wins.
- R2: A vector word always has bits 31..23 zero, bits 22..7 equal to `base_i` at the moment of presentation, bits 6..2 equal to the winning source index, and bits 1..0 zero.
- R3: Bit 0 of `vec_en_i` selects vectored mode for the normal class and bit 1 selects it for the fast class. With the bit clear, the class request output is the registered OR of its status (subject to R9), its vector output is zero, and its acknowledge and end-of-service inputs have no effect.
- R4: Request and vector outputs change one clock after the inputs that cause the change. While a class holds its request high in vectored mode, its vector does not change.
- R5: An acknowledge sampled while the class request is high pushes the presented level, and the request goes low in the next cycle. An acknowledge sampled while the request is low has no effect.
- R6: A candidate is presented only when the nesting stack is empty or the candidate's code is strictly smaller than the code on top of the stack.
- R7: End-of-service pops one level. On an empty stack it has no effect. When it arrives in the same cycle as an acknowledge, the pop is applied first and then the push.
- R8: A push onto a full stack (`NEST_DEPTH` entries, default 8) is dropped and sets the class overflow output. Only reset clears that output.
- R9: If the fast request output is high, or the fast stack is non-empty, in a cycle, then the normal request output is low in the next cycle.
- R10: During and right after reset, all request, vector and overflow outputs are zero and both stacks are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vec_en_i | input | 2 | Vectored mode: bit 0 normal class, bit 1 fast class |
| base_i | input | 16 | Vector base placed in bits 22..7 |
| prio_i | input | 96 | Packed 3-bit priority codes, source i at bits 3i+2..3i |
| norm_status_i | input | 32 | Masked normal-class requests |
| fast_status_i | input | 32 | Masked fast-class requests |
| norm_ack_i | input | 1 | Normal-class acknowledge strobe |
| norm_eos_i | input | 1 | Normal-class end-of-service strobe |
| fast_ack_i | input | 1 | Fast-class acknowledge strobe |
| fast_eos_i | input | 1 | Fast-class end-of-service strobe |
| norm_req_o | output | 1 | Normal-class request |
| norm_vec_o | output | 32 | Normal-class vector word |
| norm_ovf_o | output | 1 | Normal-class sticky nesting overflow |
| fast_req_o | output | 1 | Fast-class request |
| fast_vec_o | output | 32 | Fast-class vector word |
| fast_ovf_o | output | 1 | Fast-class sticky nesting overflow |

## Verification
Several properties are checked on every cycle by assertions:
- the vector stays stable while a vectored request is held;
- the request drops after an accepted acknowledge;
- the normal class is suppressed after a fast request;
- the vector is zero and the fast request follows its status OR in non-vectored mode;
- the overflow flags are sticky.

Other behaviour depends on history and only the bench scenarios can show it: which source wins among ties, whether a request that is not strictly more urgent stays hidden behind the nesting stack, pop-then-push ordering, stray acknowledges, and overflow at a reduced stack depth. These are compared every cycle against a queue-based model in the bench, for two instances of different depths.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int VIC_NUM_CLASS = 2;
  localparam int VIC_LOW_ZEROS = 2;

  typedef enum int {
    CLS_NORM = 0,
    CLS_FAST = 1
  } vic_class_e;
endpackage

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
  parameter int NSRC = 32,
  parameter int LVLW = 3,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]      status_i,
  input  logic [NSRC*LVLW-1:0] prio_i,
  output logic                 found_o,
  output logic [IDW-1:0]       win_id_o,
  output logic [LVLW-1:0]      win_code_o
);
  // Walk from the highest index down; "<=" lets a lower index take over on a tie.
  always_comb begin
    found_o    = 1'b0;
    win_id_o   = '0;
    win_code_o = '1;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (status_i[i] && (!found_o || (prio_i[i*LVLW +: LVLW] <= win_code_o))) begin
        found_o    = 1'b1;
        win_code_o = prio_i[i*LVLW +: LVLW];
        win_id_o   = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/vic_nest_stack.sv
module vic_nest_stack #(
  parameter int DEPTH = 8,
  parameter int LVLW  = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [LVLW-1:0] push_code_i,
  output logic            empty_o,
  output logic [LVLW-1:0] top_code_o,
  output logic            ovf_o
);
  logic [LVLW-1:0] mem_q [DEPTH];
  logic [LVLW-1:0] mem_d [DEPTH];
  logic [CW-1:0]   cnt_q, cnt_d, cnt_pop;
  logic            ovf_q, ovf_d;
  logic            upd_en;

  // Pop first, then push into the freed or next slot.
  always_comb begin
    cnt_pop = (pop_i && (cnt_q != '0)) ? cnt_q - CW'(1) : cnt_q;
    cnt_d   = cnt_pop;
    ovf_d   = ovf_q;
    for (int k = 0; k < DEPTH; k++) mem_d[k] = mem_q[k];
    if (push_i) begin
      if (cnt_pop == CW'(DEPTH)) begin
        ovf_d = 1'b1;
      end else begin
        for (int k = 0; k < DEPTH; k++) begin
          if (CW'(k) == cnt_pop) mem_d[k] = push_code_i;
        end
        cnt_d = cnt_pop + CW'(1);
      end
    end
  end

  assign upd_en = push_i | pop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= mem_d[k];
    end
  end

  always_comb begin
    top_code_o = '1;
    for (int k = 0; k < DEPTH; k++) begin
      if (CW'(k + 1) == cnt_q) top_code_o = mem_q[k];
    end
  end

  assign empty_o = (cnt_q == '0);
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/vic_class_ctrl.sv
module vic_class_ctrl #(
  parameter int NSRC  = 32,
  parameter int LVLW  = 3,
  parameter int DEPTH = 8,
  parameter int BASEW = 16,
  parameter int VECW  = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vec_en_i,
  input  logic                 hold_off_i,
  input  logic [NSRC-1:0]      status_i,
  input  logic [NSRC*LVLW-1:0] prio_i,
  input  logic [BASEW-1:0]     base_i,
  input  logic                 ack_i,
  input  logic                 eos_i,
  output logic                 req_o,
  output logic [VECW-1:0]      vec_o,
  output logic                 ovf_o,
  output logic                 busy_o
);
  import vic_pkg::*;

  localparam int IDW  = $clog2(NSRC);
  localparam int PADW = VECW - BASEW - IDW - VIC_LOW_ZEROS;

  logic            found;
  logic [IDW-1:0]  win_id;
  logic [LVLW-1:0] win_code;
  logic            nest_empty;
  logic [LVLW-1:0] nest_top;
  logic            presentable, shown, push, pop;
  logic            req_q, req_d, vfl_q, vfl_d, reg_en;
  logic [VECW-1:0] vec_q, vec_d;
  logic [LVLW-1:0] lvl_q, lvl_d;

  vic_prio_pick #(.NSRC(NSRC), .LVLW(LVLW)) pick_i (
    .status_i   (status_i),
    .prio_i     (prio_i),
    .found_o    (found),
    .win_id_o   (win_id),
    .win_code_o (win_code)
  );

  vic_nest_stack #(.DEPTH(DEPTH), .LVLW(LVLW)) nest_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .pop_i       (pop),
    .push_code_i (lvl_q),
    .empty_o     (nest_empty),
    .top_code_o  (nest_top),
    .ovf_o       (ovf_o)
  );

  assign presentable = found && (nest_empty || (win_code < nest_top)) && !hold_off_i;
  assign shown       = req_q && vfl_q;
  assign push        = vec_en_i && ack_i && shown;
  assign pop         = vec_en_i && eos_i;

  always_comb begin
    req_d = req_q;
    vec_d = vec_q;
    lvl_d = lvl_q;
    vfl_d = vec_en_i;
    if (!vec_en_i) begin
      req_d = (|status_i) && !hold_off_i;
      vec_d = '0;
    end else if (push) begin
      req_d = 1'b0;
    end else if (shown && presentable) begin
      req_d = 1'b1;
    end else if (presentable) begin
      req_d = 1'b1;
      vec_d = {{PADW{1'b0}}, base_i, win_id, {VIC_LOW_ZEROS{1'b0}}};
      lvl_d = win_code;
    end else begin
      req_d = 1'b0;
    end
  end

  assign reg_en = (req_d != req_q) || (vfl_d != vfl_q) || (vec_d != vec_q) || (lvl_d != lvl_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      vfl_q <= 1'b0;
      vec_q <= '0;
      lvl_q <= '0;
    end else if (reg_en) begin
      req_q <= req_d;
      vfl_q <= vfl_d;
      vec_q <= vec_d;
      lvl_q <= lvl_d;
    end
  end

  assign req_o  = req_q;
  assign vec_o  = vec_q;
  assign busy_o = req_q || !nest_empty;
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int NSRC       = 32,
  parameter int LVLW       = 3,
  parameter int NEST_DEPTH = 8,
  parameter int BASEW      = 16,
  parameter int VECW       = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           vec_en_i,
  input  logic [BASEW-1:0]     base_i,
  input  logic [NSRC*LVLW-1:0] prio_i,
  input  logic [NSRC-1:0]      norm_status_i,
  input  logic [NSRC-1:0]      fast_status_i,
  input  logic                 norm_ack_i,
  input  logic                 norm_eos_i,
  input  logic                 fast_ack_i,
  input  logic                 fast_eos_i,
  output logic                 norm_req_o,
  output logic [VECW-1:0]      norm_vec_o,
  output logic                 norm_ovf_o,
  output logic                 fast_req_o,
  output logic [VECW-1:0]      fast_vec_o,
  output logic                 fast_ovf_o
);
  import vic_pkg::*;

  logic [NSRC-1:0] cls_status [VIC_NUM_CLASS];
  logic            cls_ack    [VIC_NUM_CLASS];
  logic            cls_eos    [VIC_NUM_CLASS];
  logic            cls_hold   [VIC_NUM_CLASS];
  logic            cls_busy   [VIC_NUM_CLASS];
  logic            cls_req    [VIC_NUM_CLASS];
  logic            cls_ovf    [VIC_NUM_CLASS];
  logic [VECW-1:0] cls_vec    [VIC_NUM_CLASS];

  assign cls_status[CLS_NORM] = norm_status_i;
  assign cls_status[CLS_FAST] = fast_status_i;
  assign cls_ack[CLS_NORM]    = norm_ack_i;
  assign cls_ack[CLS_FAST]    = fast_ack_i;
  assign cls_eos[CLS_NORM]    = norm_eos_i;
  assign cls_eos[CLS_FAST]    = fast_eos_i;

  // The fast class gates the normal class; nothing gates the fast class.
  assign cls_hold[CLS_NORM] = cls_busy[CLS_FAST];
  assign cls_hold[CLS_FAST] = 1'b0;

  for (genvar c = 0; c < VIC_NUM_CLASS; c++) begin : g_class
    vic_class_ctrl #(
      .NSRC(NSRC), .LVLW(LVLW), .DEPTH(NEST_DEPTH), .BASEW(BASEW), .VECW(VECW)
    ) ctrl_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .vec_en_i   (vec_en_i[c]),
      .hold_off_i (cls_hold[c]),
      .status_i   (cls_status[c]),
      .prio_i     (prio_i),
      .base_i     (base_i),
      .ack_i      (cls_ack[c]),
      .eos_i      (cls_eos[c]),
      .req_o      (cls_req[c]),
      .vec_o      (cls_vec[c]),
      .ovf_o      (cls_ovf[c]),
      .busy_o     (cls_busy[c])
    );
  end

  assign norm_req_o = cls_req[CLS_NORM];
  assign norm_vec_o = cls_vec[CLS_NORM];
  assign norm_ovf_o = cls_ovf[CLS_NORM];
  assign fast_req_o = cls_req[CLS_FAST];
  assign fast_vec_o = cls_vec[CLS_FAST];
  assign fast_ovf_o = cls_ovf[CLS_FAST];
endmodule

// File: rtl/vic_arbiter_chk.sv
module vic_arbiter_chk #(
  parameter int NSRC = 32,
  parameter int VECW = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      vec_en_i,
  input logic [NSRC-1:0] fast_status_i,
  input logic            norm_ack_i,
  input logic            fast_ack_i,
  input logic            norm_req_o,
  input logic [VECW-1:0] norm_vec_o,
  input logic            norm_ovf_o,
  input logic            fast_req_o,
  input logic [VECW-1:0] fast_vec_o,
  input logic            fast_ovf_o
);
  p_norm_vec_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_en_i[0] && $past(vec_en_i[0]) && norm_req_o) |=> (!norm_req_o || $stable(norm_vec_o)));

  p_fast_vec_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_en_i[1] && $past(vec_en_i[1]) && fast_req_o) |=> (!fast_req_o || $stable(fast_vec_o)));

  p_norm_ack_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_en_i[0] && $past(vec_en_i[0]) && norm_ack_i && norm_req_o) |=> !norm_req_o);

  p_fast_ack_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_en_i[1] && $past(vec_en_i[1]) && fast_ack_i && fast_req_o) |=> !fast_req_o);

  p_norm_plain_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_en_i[0] |=> (norm_vec_o == '0));

  p_fast_plain_or_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_en_i[1] |=> (fast_req_o == $past(|fast_status_i)));

  p_fast_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_req_o |=> !norm_req_o);

  p_norm_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    norm_ovf_o |=> norm_ovf_o);

  p_fast_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_ovf_o |=> fast_ovf_o);
endmodule

bind vic_arbiter vic_arbiter_chk #(.NSRC(NSRC), .VECW(VECW)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .vec_en_i      (vec_en_i),
  .fast_status_i (fast_status_i),
  .norm_ack_i    (norm_ack_i),
  .fast_ack_i    (fast_ack_i),
  .norm_req_o    (norm_req_o),
  .norm_vec_o    (norm_vec_o),
  .norm_ovf_o    (norm_ovf_o),
  .fast_req_o    (fast_req_o),
  .fast_vec_o    (fast_vec_o),
  .fast_ovf_o    (fast_ovf_o)
);

// File: tb/vic_arbiter_tb_top.sv
`timescale 1ns/1ps
module vic_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ven = '0;
  logic [15:0] base = '0;
  logic [95:0] prio = '0;
  logic [31:0] ns = '0, fs = '0;
  logic        nack = 1'b0, neos = 1'b0, fack = 1'b0, feos = 1'b0;

  logic        o_nreq [2], o_freq [2], o_novf [2], o_fovf [2];
  logic [31:0] o_nvec [2], o_fvec [2];

  int    checks = 0, fails = 0;
  bit    done = 1'b0;
  string phase = "R10";

  always #4 clk = ~clk;

  vic_arbiter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .vec_en_i(ven), .base_i(base), .prio_i(prio),
    .norm_status_i(ns), .fast_status_i(fs), .norm_ack_i(nack), .norm_eos_i(neos),
    .fast_ack_i(fack), .fast_eos_i(feos),
    .norm_req_o(o_nreq[0]), .norm_vec_o(o_nvec[0]), .norm_ovf_o(o_novf[0]),
    .fast_req_o(o_freq[0]), .fast_vec_o(o_fvec[0]), .fast_ovf_o(o_fovf[0]));

  vic_arbiter #(.NEST_DEPTH(4)) dut_small_i (
    .clk_i(clk), .rst_ni(rst_n), .vec_en_i(ven), .base_i(base), .prio_i(prio),
    .norm_status_i(ns), .fast_status_i(fs), .norm_ack_i(nack), .norm_eos_i(neos),
    .fast_ack_i(fack), .fast_eos_i(feos),
    .norm_req_o(o_nreq[1]), .norm_vec_o(o_nvec[1]), .norm_ovf_o(o_novf[1]),
    .fast_req_o(o_freq[1]), .fast_vec_o(o_fvec[1]), .fast_ovf_o(o_fovf[1]));

  // Reference model: [instance][class], class 0 normal, class 1 fast.
  int          lim [2] = '{8, 4};
  bit          m_req [2][2];
  bit          m_vf  [2][2];
  bit          m_ovf [2][2];
  bit [31:0]   m_vec [2][2];
  int          m_lvl [2][2];
  int          m_stk [2][2][$];

  task automatic model_reset();
    for (int d = 0; d < 2; d++)
      for (int c = 0; c < 2; c++) begin
        m_req[d][c] = 0; m_vf[d][c] = 0; m_ovf[d][c] = 0;
        m_vec[d][c] = 0; m_lvl[d][c] = 0; m_stk[d][c].delete();
      end
  endtask

  task automatic model_step(int d);
    bit hold [2];
    hold[1] = 0;
    hold[0] = m_req[d][1] || (m_stk[d][1].size() != 0);
    for (int c = 0; c < 2; c++) begin
      bit [31:0] st = (c == 1) ? fs : ns;
      bit en  = ven[c];
      bit ack = (c == 1) ? fack : nack;
      bit eos = (c == 1) ? feos : neos;
      int best = 99, id = -1;
      bit pres, shown;
      for (int i = 0; i < 32; i++)
        if (st[i] && int'(prio[3*i +: 3]) < best) begin best = int'(prio[3*i +: 3]); id = i; end
      pres = (id >= 0) && ((m_stk[d][c].size() == 0) || (best < m_stk[d][c][$])) && !hold[c];
      shown = m_req[d][c] && m_vf[d][c];
      m_vf[d][c] = en;
      if (!en) begin
        m_req[d][c] = (st != 0) && !hold[c];
        m_vec[d][c] = 0;
      end else begin
        if (eos && m_stk[d][c].size() > 0) void'(m_stk[d][c].pop_back());
        if (ack && shown) begin
          if (m_stk[d][c].size() == lim[d]) m_ovf[d][c] = 1;
          else m_stk[d][c].push_back(m_lvl[d][c]);
          m_req[d][c] = 0;
        end else if (shown && pres) begin
          m_req[d][c] = 1;
        end else if (pres) begin
          m_req[d][c] = 1;
          m_vec[d][c] = {9'b0, base, 5'(id), 2'b00};
          m_lvl[d][c] = best;
        end else begin
          m_req[d][c] = 0;
        end
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      model_step(0);
      model_step(1);
    end
  end

  task automatic cmp(string what, int d, bit [31:0] act, bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s inst%0d: actual %h expected %h", phase, what, d, act, exp);
    end
  endtask

  // Outputs compared every cycle, away from the rising edge.
  always @(negedge clk) begin
    if (!done) begin
      for (int d = 0; d < 2; d++) begin
        cmp("norm_req", d, 32'(o_nreq[d]), 32'(m_req[d][0]));
        cmp("norm_vec", d, o_nvec[d], m_vec[d][0]);
        cmp("norm_ovf", d, 32'(o_novf[d]), 32'(m_ovf[d][0]));
        cmp("fast_req", d, 32'(o_freq[d]), 32'(m_req[d][1]));
        cmp("fast_vec", d, o_fvec[d], m_vec[d][1]);
        cmp("fast_ovf", d, 32'(o_fovf[d]), 32'(m_ovf[d][1]));
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(bit fast, bit is_eos);
    if (fast) begin if (is_eos) feos = 1; else fack = 1; end
    else begin if (is_eos) neos = 1; else nack = 1; end
    step(1);
    nack = 0; neos = 0; fack = 0; feos = 0;
  endtask

  task automatic set_code(int src, int code);
    prio[3*src +: 3] = 3'(code);
  endtask

  task automatic report();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8ns * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    phase = "R10"; step(3);

    // R3: plain OR mode, vector zero, strobes ignored
    phase = "R3";
    ns = 32'h10; step(2); fs = 32'h1; step(3); fs = 0; step(2);
    pulse(0, 0); pulse(0, 1); ns = 0; step(3);

    // R1 / R2: codes, ties, vector layout
    phase = "R1";
    for (int i = 0; i < 32; i++) set_code(i, 7);
    set_code(4, 2); set_code(9, 2); set_code(20, 5); set_code(25, 0); set_code(30, 1);
    ven = 2'b11; base = 16'hA5C3;
    ns = (32'h1 << 9) | (32'h1 << 20); step(3);
    phase = "R2";
    ns = 0; step(2); base = 16'h3C5A; ns = (32'h1 << 4) | (32'h1 << 9); step(3);

    // R5: acknowledge pushes; stray acknowledge ignored
    phase = "R5";
    pulse(0, 0); step(3);
    ns = 0; step(2); pulse(0, 0); step(2);
    ns = (32'h1 << 4); step(3);

    // R6: only strictly higher levels preempt (top code is 2)
    phase = "R6";
    ns = (32'h1 << 4) | (32'h1 << 9) | (32'h1 << 20); step(3);
    ns |= (32'h1 << 30); step(3); pulse(0, 0); step(3);
    ns |= (32'h1 << 25); step(3);

    // R4: held vector survives base change and more urgent arrivals
    phase = "R4";
    base = 16'hFFFF; step(3); pulse(0, 0); step(3);

    // R7: pop order, empty pops, simultaneous pop and push
    phase = "R7";
    pulse(0, 1); step(3);
    nack = 1; neos = 1; step(1); nack = 0; neos = 0; step(3);
    repeat (10) pulse(0, 1);
    step(3);

    // R8: deep nesting overflows the 4-entry instance only
    phase = "R8";
    ns = 0;
    for (int k = 0; k < 5; k++) set_code(10 + k, 7 - k);
    for (int k = 0; k < 5; k++) begin
      ns[10 + k] = 1'b1; step(3); pulse(0, 0); step(2);
    end
    step(3); repeat (10) pulse(0, 1); ns = 0; step(3);

    // R9: fast class suppresses normal
    phase = "R9";
    ns = (32'h1 << 25); step(3);
    fs = (32'h1 << 30); step(3); pulse(1, 0); step(3);
    fs = 0; step(2); pulse(1, 1); step(4);
    ven = 2'b01; fs = 32'h8; step(3); fs = 0; step(3); ns = 0; step(2);

    // Mixed traffic over all behaviours
    phase = "RMIX";
    for (int n = 0; n < 4000; n++) begin
      if (n % 250 == 0) ven = 2'($urandom);
      if (n % 500 == 0) prio = {$urandom, $urandom, $urandom};
      if (n % 3 == 0) begin
        ns = $urandom & $urandom & $urandom;
        fs = $urandom & $urandom & $urandom & $urandom;
      end
      if (n % 97 == 0) base = 16'($urandom);
      nack = ($urandom % 4) == 0;
      neos = ($urandom % 5) == 0;
      fack = ($urandom % 4) == 0;
      feos = ($urandom % 5) == 0;
      step(1);
    end
    nack = 0; neos = 0; fack = 0; feos = 0;
    step(4);
    report();
  end
endmodule